// File: doc/BRIEF.md
# Two-Lane Shared-Adder Triple-Sum Datapath

This block forms two three-operand sums at once: `out1 = a + b + c` and `out2 = d + e + f`. It has exactly two adders and four data registers. Each adder and each register is reused over a fixed sequence of control steps.

Each of the two lanes pairs an accumulating register with an operand register. The accumulating register holds the first operand, then the partial sum, and finally the result. The operand register holds the second operand and is then reloaded with the third. Input multiplexers in front of each register pick, per control step, whether it keeps its value, takes a port operand or takes its adder's output.

A single-cycle `start` launches a computation. Four operands are taken on the following edge and the two late operands on the edge after that. `done` pulses once when both results sit on `out1` and `out2`. The results stay there until the next computation begins loading.

Top module: `shared_sum_dp`

## Requirements
- R1: While reset is asserted and right after it is released, `out1`, `out2` and `done` are all zero.
- R2: When `done` is high, `out1` equals a+b+c and `out2` equals d+e+f, using the operand values taken as R5 describes.
- R3: Every sum is truncated to WIDTH bits, so it wraps modulo 2^WIDTH; for example, three operands of all ones give all ones minus two.
- R4: `done` is high for exactly one cycle. If `start` is sampled high at rising edge k while idle, `done` is high from edge k+3 until edge k+4.
- R5: `a`, `b`, `d` and `e` are taken at edge k+1, and `c` and `f` at edge k+2. Operand values at any other edge have no effect on the results.
- R6: `start` has no effect from edge k+1 through edge k+4, so a held or repeated `start` during a computation yields no extra `done`.
- R7: After `done`, `out1` and `out2` keep their result values until edge k'+1 of the next accepted `start` at edge k'.
- R8: Register reuse is visible on the outputs. Between edges k+1 and k+2, `out1`=a and `out2`=d. Between edges k+2 and k+3, `out1`=a+b and `out2`=d+e.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches a computation when the block is idle |
| a | input | WIDTH | First operand of sum 1, taken at edge k+1 |
| b | input | WIDTH | Second operand of sum 1, taken at edge k+1 |
| c | input | WIDTH | Third operand of sum 1, taken at edge k+2 |
| d | input | WIDTH | First operand of sum 2, taken at edge k+1 |
| e | input | WIDTH | Second operand of sum 2, taken at edge k+1 |
| f | input | WIDTH | Third operand of sum 2, taken at edge k+2 |
| out1 | output | WIDTH | Register 1 contents: a, then a+b, then a+b+c |
| out2 | output | WIDTH | Register 3 contents: d, then d+e, then d+e+f |
| done | output | 1 | One-cycle flag marking valid results |

## Verification
With `start` sampled at edge k, the loaded first operands are due after edge k+1 and the partial sums after edge k+2. The `done` pulse and both final sums are due after edge k+3, and `done` must be low again after edge k+4. The driver samples on falling edges and so checks each of these in the half-cycle after the edge that produces it. It drives the true operands only in the cycle in which they are due to be taken and drives random values at every other time. The monitor compares final sums at the falling edge that follows the rise of `done`.

// File: rtl/sumdp_pkg.sv
package sumdp_pkg;

    // Control steps of one computation.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LOAD  = 3'd1,
        ST_STEP1 = 3'd2,
        ST_STEP2 = 3'd3,
        ST_DONE  = 3'd4
    } sumdp_state_e;

    // Source choice for a register input multiplexer.
    typedef enum logic [1:0] {
        SRC_HOLD  = 2'd0,
        SRC_EARLY = 2'd1,
        SRC_LATE  = 2'd2,
        SRC_SUM   = 2'd3
    } sumdp_src_e;

    // Per-step steering for one lane.
    typedef struct packed {
        sumdp_src_e acc_sel;
        sumdp_src_e opd_sel;
    } sumdp_lane_ctl_t;

    typedef struct packed {
        sumdp_state_e state;
    } sumdp_ctrl_reg_t;

endpackage

// File: rtl/sumdp_adder.sv
module sumdp_adder #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] lhs,
    input  logic [WIDTH-1:0] rhs,
    output logic [WIDTH-1:0] sum
);

    // Carry out is dropped, so results wrap modulo 2^WIDTH.
    always_comb begin
        sum = lhs + rhs;
    end

endmodule

// File: rtl/sumdp_ctrl.sv
module sumdp_ctrl
    import sumdp_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    output sumdp_lane_ctl_t lane_ctl,
    output sumdp_state_e    state,
    output logic            done
);

    sumdp_ctrl_reg_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        lane_ctl = '{acc_sel: SRC_HOLD, opd_sel: SRC_HOLD};
        unique case (r_q.state)
            ST_IDLE: begin
                if (start) r_d.state = ST_LOAD;
            end
            ST_LOAD: begin
                lane_ctl  = '{acc_sel: SRC_EARLY, opd_sel: SRC_EARLY};
                r_d.state = ST_STEP1;
            end
            ST_STEP1: begin
                lane_ctl  = '{acc_sel: SRC_SUM, opd_sel: SRC_LATE};
                r_d.state = ST_STEP2;
            end
            ST_STEP2: begin
                lane_ctl  = '{acc_sel: SRC_SUM, opd_sel: SRC_HOLD};
                r_d.state = ST_DONE;
            end
            ST_DONE: begin
                r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_IDLE};
        else        r_q <= r_d;
    end

    assign state = r_q.state;
    assign done  = (r_q.state == ST_DONE);

endmodule

// File: rtl/sumdp_lane.sv
module sumdp_lane
    import sumdp_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  sumdp_lane_ctl_t  ctl,
    input  logic [WIDTH-1:0] first_op,
    input  logic [WIDTH-1:0] second_op,
    input  logic [WIDTH-1:0] third_op,
    output logic [WIDTH-1:0] acc_out
);

    typedef struct packed {
        logic [WIDTH-1:0] acc;
        logic [WIDTH-1:0] opd;
    } lane_reg_t;

    lane_reg_t        r_d, r_q;
    logic [WIDTH-1:0] sum;

    sumdp_adder #(.WIDTH(WIDTH)) adder_i (
        .lhs (r_q.acc),
        .rhs (r_q.opd),
        .sum (sum)
    );

    always_comb begin
        r_d = r_q;
        // Accumulating register: port operand or adder output.
        unique case (ctl.acc_sel)
            SRC_EARLY: r_d.acc = first_op;
            SRC_SUM:   r_d.acc = sum;
            default:   r_d.acc = r_q.acc;
        endcase
        // Operand register: early or late port operand.
        unique case (ctl.opd_sel)
            SRC_EARLY: r_d.opd = second_op;
            SRC_LATE:  r_d.opd = third_op;
            default:   r_d.opd = r_q.opd;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign acc_out = r_q.acc;

endmodule

// File: rtl/shared_sum_dp.sv
module shared_sum_dp
    import sumdp_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [WIDTH-1:0] c,
    input  logic [WIDTH-1:0] d,
    input  logic [WIDTH-1:0] e,
    input  logic [WIDTH-1:0] f,
    output logic [WIDTH-1:0] out1,
    output logic [WIDTH-1:0] out2,
    output logic             done
);

    localparam int NUM_LANES = 2;

    sumdp_lane_ctl_t                      lane_ctl;
    sumdp_state_e                         ctrl_state;
    logic [NUM_LANES-1:0][WIDTH-1:0]      op_first;
    logic [NUM_LANES-1:0][WIDTH-1:0]      op_second;
    logic [NUM_LANES-1:0][WIDTH-1:0]      op_third;
    logic [NUM_LANES-1:0][WIDTH-1:0]      lane_acc;

    assign op_first  = {d, a};
    assign op_second = {e, b};
    assign op_third  = {f, c};

    sumdp_ctrl ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .lane_ctl (lane_ctl),
        .state    (ctrl_state),
        .done     (done)
    );

    for (genvar gi = 0; gi < NUM_LANES; gi++) begin : g_lane
        sumdp_lane #(.WIDTH(WIDTH)) lane_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .ctl       (lane_ctl),
            .first_op  (op_first[gi]),
            .second_op (op_second[gi]),
            .third_op  (op_third[gi]),
            .acc_out   (lane_acc[gi])
        );
    end

    assign out1 = lane_acc[0];
    assign out2 = lane_acc[1];

endmodule

// File: rtl/shared_sum_dp_chk.sv
module shared_sum_dp_chk
    import sumdp_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic [WIDTH-1:0] c,
    input logic [WIDTH-1:0] d,
    input logic [WIDTH-1:0] e,
    input logic [WIDTH-1:0] f,
    input logic [WIDTH-1:0] out1,
    input logic [WIDTH-1:0] out2,
    input logic             done,
    input sumdp_state_e     state
);

    p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(start, 4));

    p_final_sums_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (out1 == WIDTH'($past(a, 3) + $past(b, 3) + $past(c, 2))) &&
                 (out2 == WIDTH'($past(d, 3) + $past(e, 3) + $past(f, 2))));

    p_partial_reuse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STEP2) |-> (out1 == WIDTH'($past(a, 2) + $past(b, 2))) &&
                                (out2 == WIDTH'($past(d, 2) + $past(e, 2))));

    p_busy_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> (state != ST_LOAD));

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> ($stable(out1) && $stable(out2)));

endmodule

bind shared_sum_dp shared_sum_dp_chk #(.WIDTH(WIDTH)) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .a     (a),
    .b     (b),
    .c     (c),
    .d     (d),
    .e     (e),
    .f     (f),
    .out1  (out1),
    .out2  (out2),
    .done  (done),
    .state (ctrl_state)
);

// File: tb/shared_sum_dp_tb_top.sv
module shared_sum_dp_tb_top;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] a = '0, b = '0, c = '0, d = '0, e = '0, f = '0;
    logic [W-1:0] out1, out2;
    logic         done;

    int           n_checks = 0;
    int           n_fail = 0;
    logic [2*W-1:0] exp_q[$];

    always #2 clk = ~clk;

    shared_sum_dp #(.WIDTH(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .a(a), .b(b), .c(c), .d(d), .e(e), .f(f),
        .out1(out1), .out2(out2), .done(done)
    );

    task automatic chk(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    task automatic scramble_early();
        a = W'($urandom); b = W'($urandom); d = W'($urandom); e = W'($urandom);
    endtask

    task automatic scramble_late();
        c = W'($urandom); f = W'($urandom);
    endtask

    // Driver: pushes the expected pair, then steps through one computation.
    task automatic run_op(input logic [W-1:0] va, vb, vc, vd, ve, vf,
                          input bit hold_start);
        logic [W-1:0] s1, s2, p1, p2;
        s1 = va + vb + vc;
        s2 = vd + ve + vf;
        p1 = va + vb;
        p2 = vd + ve;
        exp_q.push_back({s1, s2});
        @(negedge clk);
        start = 1'b1;
        scramble_early();
        scramble_late();
        @(negedge clk);                       // after edge k: LOAD
        if (!hold_start) start = 1'b0;
        a = va; b = vb; d = vd; e = ve;
        scramble_late();
        @(negedge clk);                       // after edge k+1
        chk("R8", "out1 loaded a", out1, va);
        chk("R8", "out2 loaded d", out2, vd);
        scramble_early();
        c = vc; f = vf;
        @(negedge clk);                       // after edge k+2
        chk("R8", "out1 partial a+b", out1, p1);
        chk("R8", "out2 partial d+e", out2, p2);
        scramble_late();
        @(negedge clk);                       // after edge k+3
        chk("R4", "done due", W'(done), W'(1));
        start = 1'b0;
        @(negedge clk);                       // after edge k+4
        chk("R4", "done single cycle", W'(done), W'(0));
        scramble_early();
        scramble_late();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R6", "no extra done", W'(done), W'(0));
            scramble_early();
        end
        chk("R7", "out1 held", out1, s1);
        chk("R7", "out2 held", out2, s2);
    endtask

    // Monitor: pops the expected pair when done is seen.
    always @(negedge clk) begin
        if (rst_n && done === 1'b1) begin
            if (exp_q.size() == 0) begin
                n_checks++;
                n_fail++;
                $display("FAIL R6 unexpected done: actual 1 expected 0");
            end else begin
                logic [2*W-1:0] exp_pair;
                exp_pair = exp_q.pop_front();
                chk("R2 R3 R5", "out1 final", out1, exp_pair[2*W-1:W]);
                chk("R2 R3 R5", "out2 final", out2, exp_pair[W-1:0]);
            end
        end
    end

    initial begin
        #(4 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL R2 watchdog: actual hung expected finished");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "out1 in reset", out1, '0);
        chk("R1", "done in reset", W'(done), '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "out1 after reset", out1, '0);
        chk("R1", "out2 after reset", out2, '0);
        chk("R1", "done after reset", W'(done), '0);

        // R2: small values, single-cycle start
        run_op(16'd1, 16'd2, 16'd3, 16'd10, 16'd20, 16'd30, 1'b0);
        // R3: wraparound on both lanes
        run_op(16'hFFFF, 16'hFFFF, 16'hFFFF, 16'h8000, 16'h8000, 16'h0001, 1'b0);
        // R6: start held high through the whole computation
        run_op(16'h1234, 16'h0F0F, 16'h00FF, 16'h0001, 16'hFFFE, 16'h0002, 1'b1);
        // R5: zero operands while garbage is driven at other edges
        run_op(16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 1'b0);
        for (int n = 0; n < 6; n++) begin
            run_op(W'($urandom), W'($urandom), W'($urandom),
                   W'($urandom), W'($urandom), W'($urandom), n[0]);
        end

        chk("R2", "scoreboard drained", W'(exp_q.size()), '0);
        summary();
    end

endmodule